// File: doc/BRIEF.md
# Stack frame save/restore sequencer

This block carries out a compact-ISA frame SAVE or RESTORE instruction once its fields have been decoded. After a one-cycle start it reads the stack pointer (register 29) through its single register-file port. It then issues one 32-bit memory access per accepted cycle, moving registers between the register file and the stack. When the walk is complete it writes the adjusted stack pointer back. Completion is signalled by a one-cycle done pulse.

The 4-bit argument code is split into two counts. One is the number of incoming-argument stores, which happen on SAVE only. The other is the number of static argument-register saves, which sit at the bottom of the frame. Return-address, extra callee-saved and s0/s1 registers are walked in a fixed, non-contiguous order below a running address. RESTORE walks the same order from stack pointer plus frame size, with loads. The short instruction form forces the extra-register and argument codes to zero and uses its own frame-size mapping. A reserved argument code returns at once with a reserved flag and touches nothing.

Top module: `frame_seq`

## Requirements
- R1: On SAVE the argument-store count comes from code_i: 0, 1, 2, 3 and 11 give 0; 4 to 7 give 1; 8 to 10 give 2; 12 and 13 give 3; 14 gives 4. The stores run first, highest register first: register 4+k is written to SP+4k, with SP the unmodified stack pointer. RESTORE performs no argument accesses.
- R2: The static-save count comes from code_i: 0, 4, 8, 12 and 14 give 0; 1, 5, 9 and 13 give 1; 2, 6 and 10 give 2; 3 and 7 give 3; 11 gives 4. These registers are taken in the order 7, 6, 5, 4 and close the walk.
- R3: After the argument stores, a running address starting at SP is decremented by 4 before each access. The access order is: 31 if ra_i; the first xs_cnt_i of 30, 23, 22, 21, 20, 19, 18; 17 if s1_i; 16 if s0_i; then the static registers. SAVE writes the register value; mem_we_o equals the SAVE select.
- R4: SAVE finishes by writing SP minus the frame size to register 29.
- R5: RESTORE starts the running address at SP plus the frame size. Each loaded word is written to its register in the same cycle the load is accepted. Register 29 finishes at SP plus the frame size.
- R6: Short form (ext_i=0): xs_cnt_i and code_i are treated as 0, and frame_i[3:0] maps 0 to 128 bytes and n to 8n bytes.
- R7: Extended form (ext_i=1): the frame size is frame_i x 8 bytes.
- R8: Extended code 15 raises rsvd_o together with done_o. It performs no memory access and no register write, and the stack pointer keeps its value.
- R9: While mem_valid_o is high and mem_ready_i is low, the request (valid, write enable, address, write data) is held unchanged in the next cycle.
- R10: done_o is high for exactly one cycle, the cycle after the register-29 write. start_i is ignored while busy_o is high.
- R11: After reset, and whenever idle, busy_o, done_o, mem_valid_o and rf_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled while idle |
| save_i | input | 1 | 1 = SAVE, 0 = RESTORE |
| ext_i | input | 1 | 1 = extended form |
| xs_cnt_i | input | 3 | Extra callee-saved register count |
| code_i | input | 4 | Argument code |
| ra_i | input | 1 | Include register 31 |
| s0_i | input | 1 | Include register 16 |
| s1_i | input | 1 | Include register 17 |
| frame_i | input | FIELD_W | Frame field, in doublewords |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rsvd_o | output | 1 | Reserved code, valid with done_o |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory request accepted |
| mem_we_o | output | 1 | Write request |
| mem_addr_o | output | DATA_W | Byte address |
| mem_wdata_o | output | DATA_W | Store data |
| mem_rdata_i | input | DATA_W | Load data, valid when accepted |
| rf_addr_o | output | 5 | Register-file address |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wdata_o | output | DATA_W | Register-file write data |
| rf_rdata_i | input | DATA_W | Register-file read data, combinational |

## Verification
The bench builds the block with its default parameters: an 8-bit frame field and a 32-bit word. The full 8-bit field brings the largest 2040-byte extended frame within reach, as well as the 128-byte short-form wrap of field value zero. Each table vector runs twice. The first pass has the memory always ready. The second pass withholds ready on every third cycle, so the hold of a stalled request is exercised on both loads and stores.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  localparam int NUM_SLOTS = 18;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int ARG_SLOTS = 4;
  localparam int XS_SLOTS  = 7;
  localparam int ST_SLOTS  = 4;
  localparam int XS_BASE   = ARG_SLOTS + 1;
  localparam int S1_SLOT   = XS_BASE + XS_SLOTS;
  localparam int S0_SLOT   = S1_SLOT + 1;
  localparam int ST_BASE   = S0_SLOT + 1;
  localparam logic [4:0] SP_REG = 5'd29;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SP_RD, ST_XFER, ST_SP_WR, ST_DONE
  } seq_state_e;

  // slot -> architectural register; order is the access order
  function automatic logic [4:0] slot_reg(input logic [SLOT_W-1:0] s);
    case (s)
      5'd0:    slot_reg = 5'd7;
      5'd1:    slot_reg = 5'd6;
      5'd2:    slot_reg = 5'd5;
      5'd3:    slot_reg = 5'd4;
      5'd4:    slot_reg = 5'd31;
      5'd5:    slot_reg = 5'd30;
      5'd6:    slot_reg = 5'd23;
      5'd7:    slot_reg = 5'd22;
      5'd8:    slot_reg = 5'd21;
      5'd9:    slot_reg = 5'd20;
      5'd10:   slot_reg = 5'd19;
      5'd11:   slot_reg = 5'd18;
      5'd12:   slot_reg = 5'd17;
      5'd13:   slot_reg = 5'd16;
      5'd14:   slot_reg = 5'd7;
      5'd15:   slot_reg = 5'd6;
      5'd16:   slot_reg = 5'd5;
      default: slot_reg = 5'd4;
    endcase
  endfunction
endpackage

// File: rtl/fseq_code_decode.sv
module fseq_code_decode (
  input  logic [3:0] code_i,
  output logic [2:0] arg_cnt_o,
  output logic [2:0] stat_cnt_o,
  output logic       rsvd_o
);
  always_comb begin
    rsvd_o = 1'b0;
    case (code_i)
      4'd4, 4'd5, 4'd6, 4'd7:   arg_cnt_o = 3'd1;
      4'd8, 4'd9, 4'd10:        arg_cnt_o = 3'd2;
      4'd12, 4'd13:             arg_cnt_o = 3'd3;
      4'd14:                    arg_cnt_o = 3'd4;
      4'd15: begin              arg_cnt_o = 3'd0; rsvd_o = 1'b1; end
      default:                  arg_cnt_o = 3'd0;
    endcase
    case (code_i)
      4'd1, 4'd5, 4'd9, 4'd13:  stat_cnt_o = 3'd1;
      4'd2, 4'd6, 4'd10:        stat_cnt_o = 3'd2;
      4'd3, 4'd7:               stat_cnt_o = 3'd3;
      4'd11:                    stat_cnt_o = 3'd4;
      default:                  stat_cnt_o = 3'd0;
    endcase
  end
endmodule

// File: rtl/fseq_frame_size.sv
module fseq_frame_size #(
  parameter int FIELD_W = 8,
  localparam int BYTES_W = FIELD_W + 3
) (
  input  logic               ext_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic [BYTES_W-1:0] bytes_o
);
  logic [3:0] nib;
  assign nib = field_i[3:0];

  always_comb begin
    if (ext_i)             bytes_o = {field_i, 3'b000};
    else if (nib == 4'd0)  bytes_o = BYTES_W'(128);
    else                   bytes_o = BYTES_W'({nib, 3'b000});
  end
endmodule

// File: rtl/fseq_slot_mask.sv
module fseq_slot_mask
  import frame_seq_pkg::*;
(
  input  logic                 save_i,
  input  logic [2:0]           xs_cnt_i,
  input  logic [2:0]           arg_cnt_i,
  input  logic [2:0]           stat_cnt_i,
  input  logic                 ra_i,
  input  logic                 s0_i,
  input  logic                 s1_i,
  output logic [NUM_SLOTS-1:0] mask_o
);
  // slot g of the argument group holds register 7-g
  for (genvar g = 0; g < ARG_SLOTS; g++) begin : g_arg
    assign mask_o[g] = save_i && (3'(ARG_SLOTS - 1 - g) < arg_cnt_i);
  end
  assign mask_o[ARG_SLOTS] = ra_i;
  for (genvar g = 0; g < XS_SLOTS; g++) begin : g_xs
    assign mask_o[XS_BASE+g] = 3'(g) < xs_cnt_i;
  end
  assign mask_o[S1_SLOT] = s1_i;
  assign mask_o[S0_SLOT] = s0_i;
  for (genvar g = 0; g < ST_SLOTS; g++) begin : g_st
    assign mask_o[ST_BASE+g] = 3'(g) < stat_cnt_i;
  end
endmodule

// File: rtl/fseq_pick.sv
module fseq_pick #(
  parameter int N = 18,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     onehot_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N:0] lower;
  assign lower[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign lower[i+1]  = lower[i] | req_i[i];
    assign onehot_o[i] = req_i[i] & ~lower[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int DATA_W  = 32,
  localparam int BYTES_W = FIELD_W + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               save_i,
  input  logic               ext_i,
  input  logic [2:0]         xs_cnt_i,
  input  logic [3:0]         code_i,
  input  logic               ra_i,
  input  logic               s0_i,
  input  logic               s1_i,
  input  logic [FIELD_W-1:0] frame_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               rsvd_o,
  output logic               mem_valid_o,
  input  logic               mem_ready_i,
  output logic               mem_we_o,
  output logic [DATA_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic [4:0]         rf_addr_o,
  output logic               rf_we_o,
  output logic [DATA_W-1:0]  rf_wdata_o,
  input  logic [DATA_W-1:0]  rf_rdata_i
);
  localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(4);

  seq_state_e state_q;
  logic                 save_q, rsvd_q;
  logic [BYTES_W-1:0]   frame_q;
  logic [NUM_SLOTS-1:0] pend_q;
  logic [DATA_W-1:0]    sp_q, run_q;

  // decode of the fields presented with start_i
  logic [2:0]           xs_eff, arg_cnt, stat_cnt;
  logic [3:0]           code_eff;
  logic                 rsvd_dec;
  logic [BYTES_W-1:0]   frame_bytes;
  logic [NUM_SLOTS-1:0] slot_mask;

  assign xs_eff   = ext_i ? xs_cnt_i : 3'd0;
  assign code_eff = ext_i ? code_i   : 4'd0;

  fseq_code_decode u_code (
    .code_i     (code_eff),
    .arg_cnt_o  (arg_cnt),
    .stat_cnt_o (stat_cnt),
    .rsvd_o     (rsvd_dec)
  );

  fseq_frame_size #(.FIELD_W(FIELD_W)) u_frame (
    .ext_i   (ext_i),
    .field_i (frame_i),
    .bytes_o (frame_bytes)
  );

  fseq_slot_mask u_mask (
    .save_i     (save_i),
    .xs_cnt_i   (xs_eff),
    .arg_cnt_i  (arg_cnt),
    .stat_cnt_i (stat_cnt),
    .ra_i       (ra_i),
    .s0_i       (s0_i),
    .s1_i       (s1_i),
    .mask_o     (slot_mask)
  );

  logic [NUM_SLOTS-1:0] cur_oh, pend_nxt;
  logic [SLOT_W-1:0]    cur_idx;
  logic                 cur_is_arg;
  logic [DATA_W-1:0]    frame_ext, arg_addr, run_dec, sp_final;

  fseq_pick #(.N(NUM_SLOTS)) u_pick (
    .req_i    (pend_q),
    .onehot_o (cur_oh),
    .idx_o    (cur_idx)
  );

  assign cur_is_arg = cur_idx < SLOT_W'(ARG_SLOTS);
  assign pend_nxt   = pend_q & ~cur_oh;
  assign frame_ext  = DATA_W'(frame_q);
  // argument slot g stores register 7-g at SP + 4*(3-g)
  assign arg_addr   = sp_q + DATA_W'({2'(ARG_SLOTS - 1) - cur_idx[1:0], 2'b00});
  assign run_dec    = run_q - WORD_BYTES;
  assign sp_final   = save_q ? sp_q - frame_ext : sp_q + frame_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      save_q  <= 1'b0;
      rsvd_q  <= 1'b0;
      frame_q <= '0;
      pend_q  <= '0;
      sp_q    <= '0;
      run_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          save_q  <= save_i;
          rsvd_q  <= rsvd_dec;
          frame_q <= frame_bytes;
          pend_q  <= rsvd_dec ? '0 : slot_mask;
          state_q <= rsvd_dec ? ST_DONE : ST_SP_RD;
        end
        ST_SP_RD: begin
          sp_q    <= rf_rdata_i;
          run_q   <= save_q ? rf_rdata_i : rf_rdata_i + frame_ext;
          state_q <= (|pend_q) ? ST_XFER : ST_SP_WR;
        end
        ST_XFER: if (mem_ready_i) begin
          pend_q <= pend_nxt;
          if (!cur_is_arg) run_q <= run_dec;
          if (pend_nxt == '0) state_q <= ST_SP_WR;
        end
        ST_SP_WR: state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid_o = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    rf_addr_o   = 5'd0;
    rf_we_o     = 1'b0;
    rf_wdata_o  = '0;
    case (state_q)
      ST_SP_RD: rf_addr_o = SP_REG;
      ST_XFER: begin
        mem_valid_o = 1'b1;
        mem_we_o    = save_q;
        mem_addr_o  = cur_is_arg ? arg_addr : run_dec;
        rf_addr_o   = slot_reg(cur_idx);
        if (save_q) begin
          mem_wdata_o = rf_rdata_i;
        end else begin
          rf_we_o    = mem_ready_i;
          rf_wdata_o = mem_rdata_i;
        end
      end
      ST_SP_WR: begin
        rf_addr_o  = SP_REG;
        rf_we_o    = 1'b1;
        rf_wdata_o = sp_final;
      end
      default: ;
    endcase
  end

  assign busy_o = state_q != ST_IDLE;
  assign done_o = state_q == ST_DONE;
  assign rsvd_o = done_o && rsvd_q;
endmodule

// File: rtl/frame_seq_checker.sv
module frame_seq_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              rsvd_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [4:0]        rf_addr_o,
  input logic              rf_we_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_we_o) &&
    $stable(mem_addr_o) && $stable(mem_wdata_o)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10

  AST_DONE_AFTER_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !rsvd_o |-> $past(rf_we_o && rf_addr_o == 5'd29)); // R10

  AST_RSVD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_o |-> done_o && $past(!mem_valid_o && !rf_we_o)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_valid_o && !rf_we_o && !done_o); // R11

  AST_STORE_NO_RFW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_we_o |-> !rf_we_o); // R1
endmodule

bind frame_seq frame_seq_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rsvd_o      (rsvd_o),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .rf_addr_o   (rf_addr_o),
  .rf_we_o     (rf_we_o)
);

// File: tb/frame_seq_test.sv
module frame_seq_test;
  localparam int DW = 32;
  localparam logic [31:0] SP0 = 32'h0000_2000;
  localparam int NV = 10;
  // {save, ext, xs[2:0], code[3:0], ra, s0, s1, frame[7:0]}
  localparam logic [19:0] VECS [NV] = '{
    {1'b1, 1'b1, 3'd0, 4'd4,  1'b1, 1'b0, 1'b0, 8'd1},
    {1'b1, 1'b1, 3'd7, 4'd14, 1'b1, 1'b1, 1'b1, 8'd3},
    {1'b1, 1'b1, 3'd2, 4'd11, 1'b0, 1'b0, 1'b1, 8'h10},
    {1'b1, 1'b0, 3'd5, 4'd13, 1'b1, 1'b1, 1'b0, 8'hF0},
    {1'b1, 1'b0, 3'd0, 4'd0,  1'b0, 1'b0, 1'b1, 8'd5},
    {1'b0, 1'b1, 3'd3, 4'd13, 1'b1, 1'b1, 1'b1, 8'h20},
    {1'b0, 1'b0, 3'd6, 4'd7,  1'b1, 1'b0, 1'b0, 8'h30},
    {1'b0, 1'b1, 3'd7, 4'd7,  1'b1, 1'b1, 1'b1, 8'hFF},
    {1'b1, 1'b1, 3'd0, 4'd0,  1'b0, 1'b0, 1'b0, 8'd2},
    {1'b0, 1'b1, 3'd1, 4'd10, 1'b0, 1'b0, 1'b0, 8'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start = 0, save = 0, ext = 0, ra = 0, s0 = 0, s1 = 0;
  logic [2:0] xs = 0;
  logic [3:0] code = 0;
  logic [7:0] field = 0;
  logic busy, done, rsvd, mvalid, mready, mwe, rfwe;
  logic [DW-1:0] maddr, mwdata, mrdata, rfwdata, rfrdata;
  logic [4:0] rfaddr;

  logic [31:0] rf [32];
  logic [31:0] mem [1024];
  logic stall_en = 1'b0;
  int unsigned cyc = 0;

  assign rfrdata = rf[rfaddr];
  assign mrdata  = mem[maddr[11:2]];
  assign mready  = !stall_en || (cyc % 3 != 1);

  frame_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .save_i(save), .ext_i(ext),
    .xs_cnt_i(xs), .code_i(code), .ra_i(ra), .s0_i(s0), .s1_i(s1),
    .frame_i(field), .busy_o(busy), .done_o(done), .rsvd_o(rsvd),
    .mem_valid_o(mvalid), .mem_ready_i(mready), .mem_we_o(mwe),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata),
    .rf_addr_o(rfaddr), .rf_we_o(rfwe), .rf_wdata_o(rfwdata),
    .rf_rdata_i(rfrdata)
  );

  int n_chk = 0, n_bad = 0;
  int log_n, rfw_n, done_n, rsvd_n, sp_cyc, done_cyc;
  logic [31:0] log_addr [64];
  logic [31:0] log_wdata [64];
  logic        log_we [64];

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rf_init(input int r);
    return 32'hA500_0000 | (r << 8) | r;
  endfunction
  function automatic logic [31:0] mem_pat(input int i);
    return 32'h9000_0000 ^ (i * 32'h0001_0203);
  endfunction

  // memory and register-file models
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mvalid && mready) begin
      if (log_n < 64) begin
        log_addr[log_n]  = maddr;
        log_wdata[log_n] = mwdata;
        log_we[log_n]    = mwe;
      end
      log_n++;
      if (mwe) mem[maddr[11:2]] <= mwdata;
    end
    if (rfwe) begin
      rf[rfaddr] <= rfwdata;
      rfw_n++;
      if (rfaddr == 5'd29) sp_cyc = int'(cyc);
    end
    if (done) begin
      done_n++;
      done_cyc = int'(cyc);
      if (rsvd) rsvd_n++;
    end
  end

  // R9: a stalled request must reappear unchanged
  logic        pv_stall = 0, pv_we = 0;
  logic [31:0] pv_addr = 0, pv_wdata = 0;
  always @(negedge clk) begin
    if (rst_n && pv_stall)
      chk(mvalid && mwe == pv_we && maddr == pv_addr && mwdata == pv_wdata,
          "R9 stalled request held", maddr, pv_addr);
    pv_stall = rst_n && mvalid && !mready;
    pv_we    = mwe;
    pv_addr  = maddr;
    pv_wdata = mwdata;
  end

  function automatic int arg_cnt_f(input logic [3:0] c);
    case (c)
      4,5,6,7: return 1;
      8,9,10:  return 2;
      12,13:   return 3;
      14:      return 4;
      default: return 0;
    endcase
  endfunction
  function automatic int stat_cnt_f(input logic [3:0] c);
    case (c)
      1,5,9,13: return 1;
      2,6,10:   return 2;
      3,7:      return 3;
      11:       return 4;
      default:  return 0;
    endcase
  endfunction

  task automatic prep();
    @(negedge clk);
    for (int r = 0; r < 32; r++) rf[r] <= (r == 29) ? SP0 : rf_init(r);
    for (int i = 0; i < 1024; i++) mem[i] <= mem_pat(i);
    log_n = 0; rfw_n = 0; done_n = 0; rsvd_n = 0; sp_cyc = -1; done_cyc = -2;
  endtask

  task automatic launch(input logic [19:0] v, input bit poke);
    @(negedge clk);
    {save, ext, xs, code, ra, s0, s1, field} = v;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int t = 0; t < 3000 && done_n == 0; t++) begin
      @(negedge clk);
      if (poke && t == 2) begin
        // R10: start while busy with a reserved code must be ignored
        save = 1; ext = 1; code = 4'd15; start = 1;
      end else start = 0;
    end
    start = 0;
    if (done_n == 0) chk(1'b0, "R10 watchdog: no done", 0, 1);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic run_vec(input logic [19:0] v, input bit poke);
    logic [31:0] e_addr [40];
    int          e_reg [40];
    int          e_tag [40];
    int e_n, argc, statc, xse, fbytes;
    logic [31:0] run, exp_sp;
    logic sv, ex;
    logic [3:0] ce;
    int xs_list [7];
    xs_list = '{30, 23, 22, 21, 20, 19, 18};
    sv = v[19]; ex = v[18];
    ce  = ex ? v[14:11] : 4'd0;
    xse = ex ? int'(v[17:15]) : 0;
    fbytes = ex ? int'(v[7:0]) * 8 : (v[3:0] == 0 ? 128 : int'(v[3:0]) * 8);
    argc = sv ? arg_cnt_f(ce) : 0;
    statc = stat_cnt_f(ce);
    e_n = 0;
    for (int k = argc - 1; k >= 0; k--) begin
      e_addr[e_n] = SP0 + 4 * k; e_reg[e_n] = 4 + k; e_tag[e_n] = 1; e_n++;
    end
    run = sv ? SP0 : SP0 + fbytes;
    if (v[10]) begin run -= 4; e_addr[e_n] = run; e_reg[e_n] = 31; e_tag[e_n] = 3; e_n++; end
    for (int k = 0; k < xse; k++) begin
      run -= 4; e_addr[e_n] = run; e_reg[e_n] = xs_list[k]; e_tag[e_n] = 3; e_n++;
    end
    if (v[8]) begin run -= 4; e_addr[e_n] = run; e_reg[e_n] = 17; e_tag[e_n] = 3; e_n++; end
    if (v[9]) begin run -= 4; e_addr[e_n] = run; e_reg[e_n] = 16; e_tag[e_n] = 3; e_n++; end
    for (int k = 0; k < statc; k++) begin
      run -= 4; e_addr[e_n] = run; e_reg[e_n] = 7 - k; e_tag[e_n] = 2; e_n++;
    end

    prep();
    launch(v, poke);

    chk(log_n == e_n, "R3 access count", log_n, e_n);
    for (int i = 0; i < e_n && i < log_n; i++) begin
      string tg;
      tg = (e_tag[i] == 1) ? "R1 arg store" : (e_tag[i] == 2) ? "R2 static access" : "R3 walk access";
      chk(log_addr[i] == e_addr[i], {tg, " address"}, log_addr[i], e_addr[i]);
      chk(log_we[i] == sv, {tg, " direction"}, 32'(log_we[i]), 32'(sv));
      if (sv)
        chk(log_wdata[i] == rf_init(e_reg[i]), {tg, " data"}, log_wdata[i], rf_init(e_reg[i]));
      else
        chk(rf[e_reg[i]] == mem_pat(int'(e_addr[i][11:2])), "R5 loaded register",
            rf[e_reg[i]], mem_pat(int'(e_addr[i][11:2])));
    end
    exp_sp = sv ? SP0 - fbytes : SP0 + fbytes;
    chk(rf[29] == exp_sp, sv ? (ex ? "R4 R7 final SP" : "R4 R6 final SP")
                             : (ex ? "R5 R7 final SP" : "R5 R6 final SP"), rf[29], exp_sp);
    chk(done_n == 1 && done_cyc == sp_cyc + 1, "R10 done pulse after SP write",
        done_cyc, sp_cyc + 1);
    chk(rsvd_n == 0, "R10 R8 no reserved flag", rsvd_n, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    log_n = 0; rfw_n = 0; done_n = 0; rsvd_n = 0;
    for (int r = 0; r < 32; r++) rf[r] = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !mvalid && !rfwe, "R11 reset outputs quiet",
        {28'd0, busy, done, mvalid, rfwe}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !mvalid && !rfwe, "R11 idle after reset", {29'd0, busy, mvalid, rfwe}, 0);

    for (int p = 0; p < 2; p++) begin
      stall_en = (p == 1);
      for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);
    end

    // R8 reserved code
    stall_en = 0;
    prep();
    launch({1'b1, 1'b1, 3'd3, 4'd15, 1'b1, 1'b1, 1'b1, 8'd4}, 1'b0);
    chk(rsvd_n == 1 && done_n == 1, "R8 reserved flag with done", rsvd_n, 1);
    chk(log_n == 0, "R8 no memory access", log_n, 0);
    chk(rfw_n == 0, "R8 no register write", rfw_n, 0);
    chk(rf[29] == SP0, "R8 SP unchanged", rf[29], SP0);

    // R10 start while busy ignored
    stall_en = 1;
    run_vec(VECS[1], 1'b1);
    stall_en = 0;
    chk(!busy, "R11 idle after operation", 32'(busy), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule